// File: doc/BRIEF.md
# Paired-Pointer Block Copy/Compare Unit

This unit carries out the four long memory instructions of a small 8-bit processor: copy going up, copy going down, compare going up and compare going down. The source pointer is the register pair A (high) : X (low). The destination pointer is B (high) : Y (low). For a copy, the unit reads the source byte and stores it at the destination. For a compare, it reads both bytes and sets the zero, carry, overflow and sign flags from source minus destination, without storing anything. In every case it then moves both pointers by one step. The carry or borrow from the low register goes into the high register, and this step leaves the flags alone.

The processor pulses `start` with an operation code and presents the four register values and the flags. The unit takes over a byte-wide synchronous memory port. After a fixed time of four base instruction slots it pulses `done` for one cycle, with the updated registers and flags on its outputs. A controller walks the states IDLE → RD_SRC → LATCH → COMMIT → (PAD, repeated as needed) → FINISH → IDLE:
- IDLE accepts `start`.
- RD_SRC issues the source read.
- LATCH captures the source byte, and for a compare also issues the destination read.
- COMMIT writes the byte for a copy, or captures the destination byte and computes the flags for a compare. It also steps both pointers.
- PAD fills out the fixed length.
- FINISH raises `done`.

Top module: `blkmv_unit`

## Requirements
- R1: `op[1]` selects compare (1) or copy (0), and `op[0]` selects decrement (1) or increment (0). `start` is taken only while `busy` is low. A `start` pulse while busy is ignored and changes neither the result nor the timing.
- R2: `done` is high for exactly one cycle, 4*SLOT_CYCLES cycles after the cycle in which `start` was accepted. `busy` stays high from the cycle after acceptance through the `done` cycle.
- R3: A copy performs one read at address {A,X} and then exactly one write of that byte to address {B,Y}.
- R4: A compare performs reads at {A,X} and then {B,Y}, and no write. `flg_o` holds {S,O,C,Z} in bits [3:0]. For diff = src − dst (8 bits): Z is set when diff is 0, C is the borrow (src < dst unsigned), O is signed overflow of the subtraction, and S is diff bit 7.
- R5: A copy returns `flg_o` equal to the `flg_i` value sampled at start.
- R6: The increment variants return X+1, with A+1 when X was 0xFF. Y and B step in the same way. 0xFFFF wraps to 0x0000 with no flag effect.
- R7: The decrement variants return X−1, with A−1 when X was 0x00. Y and B step in the same way. 0x0000 wraps to 0xFFFF with no flag effect.
- R8: Memory read data is taken the cycle after `mem_rd`. `mem_rd` and `mem_wr` are never high together, and both are low while idle.
- R9: After reset, `busy`, `done`, `mem_rd` and `mem_wr` are low and all register and flag outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken when idle) |
| op | input | 2 | [1]=compare, [0]=decrement |
| a_i | input | DW | Source pointer high byte |
| x_i | input | DW | Source pointer low byte |
| b_i | input | DW | Destination pointer high byte |
| y_i | input | DW | Destination pointer low byte |
| flg_i | input | 4 | Flags in, {S,O,C,Z} |
| a_o | output | DW | Updated A |
| x_o | output | DW | Updated X |
| b_o | output | DW | Updated B |
| y_o | output | DW | Updated Y |
| flg_o | output | 4 | Flags out, {S,O,C,Z} |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| mem_addr | output | 2*DW | Memory byte address |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid one cycle after `mem_rd` |

## Verification
A controller that skips or repeats a state shows up first in the cycle count to `done`, which must come exactly 4*SLOT_CYCLES cycles after start. It also shows up in the number and order of memory accesses recorded during that operation. A wrong captured byte or a lost carry between the low and high registers shows at the `done` cycle as a wrong address on the port, a wrong written byte, wrong flags or a wrong register pair. Pointer values at the wrap points and a start pulse raised mid-operation are driven on purpose, so faults there appear within one operation.

// File: rtl/blkmv_pkg.sv
package blkmv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD_SRC = 3'd1,
        ST_LATCH  = 3'd2,
        ST_COMMIT = 3'd3,
        ST_PAD    = 3'd4,
        ST_FINISH = 3'd5
    } blk_state_e;

    typedef struct packed {
        logic s;
        logic o;
        logic c;
        logic z;
    } blk_flags_t;

endpackage

// File: rtl/blkmv_ptr_step.sv
module blkmv_ptr_step #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] hi_i,
    input  logic [DW-1:0] lo_i,
    input  logic          dec_i,
    output logic [DW-1:0] hi_o,
    output logic [DW-1:0] lo_o
);
    localparam logic [DW-1:0] ALL_ONES = {DW{1'b1}};
    localparam logic [DW-1:0] ONE      = {{(DW-1){1'b0}}, 1'b1};

    logic lo_edge;

    always_comb begin
        lo_edge = dec_i ? (lo_i == '0) : (lo_i == ALL_ONES);
        if (dec_i) begin
            lo_o = lo_i - ONE;
            hi_o = lo_edge ? hi_i - ONE : hi_i;
        end else begin
            lo_o = lo_i + ONE;
            hi_o = lo_edge ? hi_i + ONE : hi_i;
        end
    end
endmodule

// File: rtl/blkmv_sub_flags.sv
module blkmv_sub_flags
    import blkmv_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] lhs_i,
    input  logic [DW-1:0] rhs_i,
    output blk_flags_t    flg_o
);
    logic [DW:0] wide;

    always_comb begin
        wide    = {1'b0, lhs_i} - {1'b0, rhs_i};
        flg_o.z = (wide[DW-1:0] == '0);
        flg_o.c = wide[DW];
        flg_o.s = wide[DW-1];
        flg_o.o = (lhs_i[DW-1] != rhs_i[DW-1]) && (wide[DW-1] != lhs_i[DW-1]);
    end
endmodule

// File: rtl/blkmv_unit.sv
module blkmv_unit
    import blkmv_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SLOT_CYCLES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      op,
    input  logic [DW-1:0]   a_i,
    input  logic [DW-1:0]   x_i,
    input  logic [DW-1:0]   b_i,
    input  logic [DW-1:0]   y_i,
    input  logic [3:0]      flg_i,
    output logic [DW-1:0]   a_o,
    output logic [DW-1:0]   x_o,
    output logic [DW-1:0]   b_o,
    output logic [DW-1:0]   y_o,
    output logic [3:0]      flg_o,
    output logic            busy,
    output logic            done,
    output logic [2*DW-1:0] mem_addr,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata
);
    localparam int TOTAL = 4 * SLOT_CYCLES;
    localparam int CW    = $clog2(TOTAL + 1);
    localparam logic [CW-1:0] LAST_PAD = CW'(TOTAL - 2);

    blk_state_e state_q, state_d;
    logic [CW-1:0] cyc_q;
    logic          is_cmp_q, is_dec_q;
    logic [DW-1:0] a_q, x_q, b_q, y_q, src_q;
    blk_flags_t    flg_q, cmp_flg;
    logic          accept;

    logic [DW-1:0] hi_cur [2];
    logic [DW-1:0] lo_cur [2];
    logic [DW-1:0] hi_nx  [2];
    logic [DW-1:0] lo_nx  [2];

    assign hi_cur[0] = a_q;
    assign lo_cur[0] = x_q;
    assign hi_cur[1] = b_q;
    assign lo_cur[1] = y_q;

    generate
        for (genvar p = 0; p < 2; p++) begin : g_ptr
            blkmv_ptr_step #(.DW(DW)) u_step (
                .hi_i  (hi_cur[p]),
                .lo_i  (lo_cur[p]),
                .dec_i (is_dec_q),
                .hi_o  (hi_nx[p]),
                .lo_o  (lo_nx[p])
            );
        end
    endgenerate

    blkmv_sub_flags #(.DW(DW)) u_flags (
        .lhs_i (src_q),
        .rhs_i (mem_rdata),
        .flg_o (cmp_flg)
    );

    assign accept = start && (state_q == ST_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_RD_SRC;
            ST_RD_SRC: state_d = ST_LATCH;
            ST_LATCH:  state_d = ST_COMMIT;
            ST_COMMIT: state_d = (cyc_q == LAST_PAD) ? ST_FINISH : ST_PAD;
            ST_PAD:    state_d = (cyc_q == LAST_PAD) ? ST_FINISH : ST_PAD;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cyc_q   <= '0;
        end else begin
            state_q <= state_d;
            cyc_q   <= (state_q == ST_IDLE) ? '0 : cyc_q + 1'b1;
        end
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q      <= '0;
            x_q      <= '0;
            b_q      <= '0;
            y_q      <= '0;
            src_q    <= '0;
            flg_q    <= '0;
            is_cmp_q <= 1'b0;
            is_dec_q <= 1'b0;
        end else if (accept) begin
            a_q      <= a_i;
            x_q      <= x_i;
            b_q      <= b_i;
            y_q      <= y_i;
            flg_q    <= flg_i;
            is_cmp_q <= op[1];
            is_dec_q <= op[0];
        end else if (state_q == ST_LATCH) begin
            src_q <= mem_rdata;
        end else if (state_q == ST_COMMIT) begin
            a_q <= hi_nx[0];
            x_q <= lo_nx[0];
            b_q <= hi_nx[1];
            y_q <= lo_nx[1];
            if (is_cmp_q) flg_q <= cmp_flg;
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_FINISH);
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = {b_q, y_q};
        mem_wdata = src_q;
        unique case (state_q)
            ST_RD_SRC: begin
                mem_rd   = 1'b1;
                mem_addr = {a_q, x_q};
            end
            ST_LATCH:  mem_rd = is_cmp_q;
            ST_COMMIT: mem_wr = !is_cmp_q;
            default: ;
        endcase
        a_o   = a_q;
        x_o   = x_q;
        b_o   = b_q;
        y_o   = y_q;
        flg_o = flg_q;
    end

    // checker state, captured from the ports at acceptance
    logic [CW-1:0]   chk_cnt;
    logic            chk_cmp, chk_dec;
    logic [3:0]      chk_flg;
    logic [2*DW-1:0] chk_src, chk_dst;
    logic [1:0]      chk_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_cnt <= '0;
            chk_cmp <= 1'b0;
            chk_dec <= 1'b0;
            chk_flg <= '0;
            chk_src <= '0;
            chk_dst <= '0;
            chk_wr  <= '0;
        end else if (start && !busy) begin
            chk_cnt <= '0;
            chk_cmp <= op[1];
            chk_dec <= op[0];
            chk_flg <= flg_i;
            chk_src <= {a_i, x_i};
            chk_dst <= {b_i, y_i};
            chk_wr  <= '0;
        end else begin
            if (chk_cnt != '1) chk_cnt <= chk_cnt + 1'b1;
            if (mem_wr && chk_wr != 2'd3) chk_wr <= chk_wr + 1'b1;
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> chk_cnt == CW'(TOTAL - 1)); // R2
    AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr)); // R8
    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> !chk_cmp); // R4
    AST_COPY_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !chk_cmp) |-> chk_wr == 2'd1); // R3
    AST_COPY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !chk_cmp) |-> flg_o == chk_flg); // R5
    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !chk_dec) |-> ({a_o, x_o} == chk_src + 1'b1 && {b_o, y_o} == chk_dst + 1'b1)); // R6
    AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && chk_dec) |-> ({a_o, x_o} == chk_src - 1'b1 && {b_o, y_o} == chk_dst - 1'b1)); // R7
endmodule

// File: tb/sim_blkmv_unit.sv
module sim_blkmv_unit;
    localparam int DW = 8;
    localparam int SLOT_CYCLES = 4;
    localparam int TOTAL = 4 * SLOT_CYCLES;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] op = '0;
    logic [7:0] a_i = '0, x_i = '0, b_i = '0, y_i = '0;
    logic [3:0] flg_i = '0;
    logic [7:0] a_o, x_o, b_o, y_o, mem_wdata;
    logic [3:0] flg_o;
    logic busy, done, mem_rd, mem_wr;
    logic [15:0] mem_addr;
    logic [7:0] mem_rdata = '0;

    int checks = 0;
    int failures = 0;

    logic [15:0] src_addr, dst_addr;
    logic [7:0]  src_val, dst_val;
    int n_rd, n_wr;
    logic [15:0] rd_a0, rd_a1, wr_a;
    logic [7:0]  wr_d;

    always #5 clk = ~clk;

    blkmv_unit #(.DW(DW), .SLOT_CYCLES(SLOT_CYCLES)) u0 (
        .clk, .rst_n, .start, .op, .a_i, .x_i, .b_i, .y_i, .flg_i,
        .a_o, .x_o, .b_o, .y_o, .flg_o, .busy, .done,
        .mem_addr, .mem_rd, .mem_wr, .mem_wdata, .mem_rdata
    );

    // synchronous memory model with access log
    always @(posedge clk) begin
        if (mem_rd) begin
            if (mem_addr == src_addr)      mem_rdata <= src_val;
            else if (mem_addr == dst_addr) mem_rdata <= dst_val;
            else                           mem_rdata <= 8'h5A;
            if (n_rd == 0) rd_a0 <= mem_addr;
            if (n_rd == 1) rd_a1 <= mem_addr;
            n_rd <= n_rd + 1;
        end
        if (mem_wr) begin
            wr_a <= mem_addr;
            wr_d <= mem_wdata;
            n_wr <= n_wr + 1;
        end
    end

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog: run did not finish, act=hung exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_flags(input logic [7:0] s, input logic [7:0] d);
        logic [8:0] w;
        logic [3:0] f;
        w = {1'b0, s} - {1'b0, d};
        f[0] = (w[7:0] == 8'h00);
        f[1] = (s < d);
        f[2] = (s[7] != d[7]) && (w[7] != s[7]);
        f[3] = w[7];
        return f;
    endfunction

    task automatic run_op(input logic [1:0] o, input logic [7:0] a, input logic [7:0] x,
                          input logic [7:0] b, input logic [7:0] y, input logic [3:0] f,
                          input logic [7:0] sv, input logic [7:0] dv, input bit glitch);
        int k;
        logic [15:0] es, ed;
        logic [3:0] ef;
        src_addr = {a, x};
        dst_addr = {b, y};
        src_val = sv;
        dst_val = dv;
        n_rd = 0;
        n_wr = 0;
        @(negedge clk);
        start = 1'b1; op = o; a_i = a; x_i = x; b_i = b; y_i = y; flg_i = f;
        k = 0;
        while (k < TOTAL + 8) begin
            @(negedge clk);
            k++;
            start = (glitch && k == 3);
            if (glitch && k == 3) begin
                op = ~o; a_i = ~a; x_i = ~x; b_i = ~b; y_i = ~y; flg_i = ~f;
            end
            if (done) break;
        end
        start = 1'b0;
        check(k == TOTAL, "R2 latency", k, TOTAL);
        es = o[0] ? {a, x} - 16'd1 : {a, x} + 16'd1;
        ed = o[0] ? {b, y} - 16'd1 : {b, y} + 16'd1;
        check({a_o, x_o} == es, o[0] ? "R7 src pointer" : "R6 src pointer", {a_o, x_o}, es);
        check({b_o, y_o} == ed, o[0] ? "R7 dst pointer" : "R6 dst pointer", {b_o, y_o}, ed);
        if (o[1]) begin
            ef = exp_flags(sv, dv);
            check(flg_o == ef, "R4 flags", flg_o, ef);
            check(n_wr == 0, "R4 no write", n_wr, 0);
            check(n_rd == 2 && rd_a0 == {a, x} && rd_a1 == {b, y}, "R4 read order", rd_a1, {b, y});
        end else begin
            check(flg_o == f, "R5 flags kept", flg_o, f);
            check(n_rd == 1 && rd_a0 == {a, x}, "R3 source read", rd_a0, {a, x});
            check(n_wr == 1 && wr_a == {b, y}, "R3 write addr", wr_a, {b, y});
            check(wr_d == sv, "R3 write data", wr_d, sv);
        end
        @(negedge clk);
        check(!done && !busy, "R2 single pulse", done, 0);
        if (glitch) begin
            repeat (TOTAL) @(negedge clk);
            check(!busy && n_wr <= 1, "R1 start while busy ignored", busy, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        n_rd = 0;
        n_wr = 0;
        src_addr = '0; dst_addr = '1; src_val = '0; dst_val = '0;
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_rd && !mem_wr, "R9 reset controls", {busy, done, mem_rd, mem_wr}, 0);
        check({a_o, x_o, b_o, y_o} == 32'h0 && flg_o == 4'h0, "R9 reset outputs", {a_o, x_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!mem_rd && !mem_wr, "R8 idle bus quiet", {mem_rd, mem_wr}, 0);

        // directed corners
        run_op(2'b00, 8'h12, 8'hFF, 8'h40, 8'hFF, 4'b1010, 8'hC3, 8'h00, 1'b0); // R6 carry into high
        run_op(2'b00, 8'hFF, 8'hFF, 8'h00, 8'h10, 4'b0101, 8'h77, 8'h00, 1'b0); // R6 wrap
        run_op(2'b01, 8'h34, 8'h00, 8'h20, 8'h00, 4'b1111, 8'h9E, 8'h00, 1'b0); // R7 borrow into high
        run_op(2'b01, 8'h00, 8'h00, 8'h80, 8'h05, 4'b0000, 8'h01, 8'h00, 1'b0); // R7 wrap
        run_op(2'b10, 8'h10, 8'h00, 8'h20, 8'h00, 4'b0000, 8'h05, 8'h05, 1'b0); // R4 equal
        run_op(2'b10, 8'h10, 8'h01, 8'h20, 8'h01, 4'b0000, 8'h80, 8'h01, 1'b0); // R4 overflow
        run_op(2'b11, 8'h10, 8'h00, 8'h20, 8'h00, 4'b1111, 8'h01, 8'h02, 1'b0); // R4 borrow
        run_op(2'b00, 8'h55, 8'h10, 8'h66, 8'h20, 4'b0011, 8'hAB, 8'h00, 1'b1); // R1 glitch copy
        run_op(2'b11, 8'h55, 8'h10, 8'h66, 8'h20, 4'b0011, 8'h7F, 8'h80, 1'b1); // R1 glitch compare

        // constrained random
        for (int i = 0; i < 40; i++) begin
            logic [7:0] ra, rx, rb, ry;
            ra = 8'($urandom); rx = 8'($urandom); rb = 8'($urandom); ry = 8'($urandom);
            if ({ra, rx} == {rb, ry}) rb = ~rb;
            run_op(2'($urandom), ra, rx, rb, ry, 4'($urandom), 8'($urandom), 8'($urandom), 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule